// File: doc/BRIEF.md
# GPIO-Conditioned Trigger Sequencer

This block decides when an acquisition system takes a frame. A trigger comes from one of two places. The first is an internal period timer that runs in stop, single-shot or repetitive mode. The second is a match on a set of general-purpose input pins, where each pin carries its own 2-bit condition code. A qualified trigger loads a programmable delay counter. When that count runs out, the block issues a one-cycle strobe to the camera logic and, in the same cycle, a request to the sync-pulse transmitter.

A separate 2-bit code per pin sets the general-purpose outputs. Each pin is either released, holds its last value, or shows the transmitter's pulse-in-progress flag in active-high or active-low form. Input pins go through a synchronizer before they are matched. A held match level fires once, on its rising edge. Triggers that arrive while a delay countdown is running are dropped.

Top module: `trig_seq`

## Requirements
- R1: While reset is asserted, and at the first clock edge after release, `trig_strobe`, `xmit_req` and `gpio_out` are all 0.
- R2: Input pins go through a two-stage synchronizer. With a delay of 0, a single qualifying pin change presented before edge k raises `trig_strobe` after edge k+2 and not earlier.
- R3: When `cond_cfg` is nonzero, bits [2i+1:2i] condition pin i. 00 ignores the pin and 01 (keep) also leaves the match unaffected. 10 requires the pin low and 11 requires it high. The match is the AND of all pins coded 10 or 11.
- R4: An external trigger fires only on a cycle where the match is true after being false in the previous cycle. A level held steady fires once.
- R5: With delay D, the strobe appears exactly D cycles later than it would with delay 0.
- R6: A trigger that arrives while a countdown is running is ignored. This includes the last cycle of the countdown, the cycle just before the strobe.
- R7: When `cond_cfg` is 0 and the period is 0 or between 2 and 255, the timer produces no triggers.
- R8: When `cond_cfg` is 0 and the period is written to 1, exactly one trigger is produced.
- R9: When `cond_cfg` is 0 and the period P is 256 or more, triggers repeat every P cycles. Any change of the period restarts the timer, so with a delay of 0 the first strobe appears P+1 cycles after the write cycle.
- R10: `trig_strobe` lasts one cycle and `xmit_req` equals it in every cycle.
- R11: `out_cfg` bits [2i+1:2i] set pin i. The output `gpio_out` is registered. Code 00 gives output 0 with enable low. Code 01 gives enable high and holds the previous value. Code 10 gives the inverse of `xmit_busy`. Code 11 gives `xmit_busy`. `gpio_oe` is high for every code except 00.
- R12: When `cond_cfg` is nonzero, the period timer produces no triggers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| gpio_in | input | NUM_PINS | Asynchronous general-purpose input pins |
| cond_cfg | input | 2*NUM_PINS | Trigger condition codes; all-zero selects the internal timer |
| delay_cfg | input | CNT_W | Trigger delay in clock cycles |
| period_cfg | input | CNT_W | Timer period: 0 stop, 1 single, at least MIN_REP repetitive |
| out_cfg | input | 2*NUM_PINS | Output mapping codes per pin |
| xmit_busy | input | 1 | Transmitter reports a sync pulse in progress |
| trig_strobe | output | 1 | One-cycle trigger event to the camera logic |
| xmit_req | output | 1 | Request to the sync-pulse transmitter |
| gpio_out | output | NUM_PINS | Driven output pin values |
| gpio_oe | output | NUM_PINS | Output enables |

## Verification
Two events can land in the same cycle: the countdown can reach its final cycle just as a new external trigger is detected. The bench provokes this with a train of input pulses whose spacing equals the programmed delay. Every second pulse then falls on a final countdown cycle and must be dropped. A second train, spaced one cycle wider, must be accepted in full. A behavioural model judges both trains cycle by cycle, and direct counts of the strobes in each train back it up.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;
   typedef enum logic [1:0] {
      PIN_OFF  = 2'b00,
      PIN_KEEP = 2'b01,
      PIN_LOW  = 2'b10,
      PIN_HIGH = 2'b11
   } pin_code_e;
endpackage

// File: rtl/trig_sync.sv
module trig_sync #(
   parameter int W      = 10,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   generate
      for (genvar k = 0; k < STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[0] <= '0;
               else        stg[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stg[k] <= '0;
               else        stg[k] <= stg[k-1];
            end
         end
      end
   endgenerate

   assign q = stg[STAGES-1];
endmodule

// File: rtl/trig_cond_match.sv
module trig_cond_match
   import trig_seq_pkg::*;
#(
   parameter int NUM_PINS = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*NUM_PINS-1:0] cond_cfg,
   input  logic [NUM_PINS-1:0]   pins,
   output logic                  ext_mode,
   output logic                  fire
);
   logic [NUM_PINS-1:0] pin_ok;
   logic                match;
   logic                match_q;

   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         pin_code_e code;
         assign code = pin_code_e'(cond_cfg[2*i +: 2]);
         always_comb begin
            case (code)
               PIN_LOW:  pin_ok[i] = ~pins[i];
               PIN_HIGH: pin_ok[i] = pins[i];
               default:  pin_ok[i] = 1'b1;
            endcase
         end
      end
   endgenerate

   assign match    = &pin_ok;
   assign ext_mode = (cond_cfg != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) match_q <= 1'b0;
      else        match_q <= match;
   end

   assign fire = ext_mode & match & ~match_q;

   // R4: an edge detection cannot repeat on the following cycle
   a_r4_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> !fire);
endmodule

// File: rtl/trig_period_timer.sv
module trig_period_timer #(
   parameter int CNT_W   = 32,
   parameter int MIN_REP = 256
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             enable,
   input  logic [CNT_W-1:0] period_cfg,
   output logic             fire
);
   localparam logic [CNT_W-1:0] REP_MIN = CNT_W'(MIN_REP);
   localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] cnt;
   logic             arm_q;
   logic             repeat_on;
   logic             wrap;
   logic             rewrite;

   assign repeat_on = (per_q >= REP_MIN);
   assign wrap      = repeat_on && (cnt == per_q - ONE);
   assign rewrite   = (period_cfg != per_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         cnt   <= '0;
         arm_q <= 1'b0;
      end else if (rewrite) begin
         per_q <= period_cfg;
         cnt   <= '0;
         arm_q <= (period_cfg == ONE);
      end else begin
         arm_q <= 1'b0;
         if (wrap)           cnt <= '0;
         else if (repeat_on) cnt <= cnt + ONE;
      end
   end

   assign fire = enable & (wrap | arm_q);

   // R7: a stopped timer stays quiet
   a_r7_stop_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q == '0 && !arm_q) |-> !fire);
   // R9: a period change restarts the count
   a_r9_restart: assert property (@(posedge clk) disable iff (!rst_n)
      rewrite |=> (cnt == '0));
endmodule

// File: rtl/trig_delay.sv
module trig_delay #(
   parameter int CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             fire,
   input  logic [CNT_W-1:0] delay_cfg,
   output logic             strobe
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] dcnt;
   logic             busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dcnt   <= '0;
         busy   <= 1'b0;
         strobe <= 1'b0;
      end else begin
         strobe <= 1'b0;
         if (busy) begin
            if (dcnt == ONE) begin
               busy   <= 1'b0;
               strobe <= 1'b1;
            end else begin
               dcnt <= dcnt - ONE;
            end
         end else if (fire) begin
            if (delay_cfg == '0) begin
               strobe <= 1'b1;
            end else begin
               busy <= 1'b1;
               dcnt <= delay_cfg;
            end
         end
      end
   end

   // R5: an accepted trigger loads the programmed delay
   a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && fire && delay_cfg != '0) |=> (busy && dcnt == $past(delay_cfg)));
   // R6: no strobe while the countdown still has cycles to run
   a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && dcnt > ONE) |=> !strobe);
   // R10: strobe lasts one cycle
   a_r10_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      strobe |=> !strobe);
endmodule

// File: rtl/trig_out_map.sv
module trig_out_map
   import trig_seq_pkg::*;
#(
   parameter int NUM_PINS = 10
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [2*NUM_PINS-1:0] out_cfg,
   input  logic                  pulse_active,
   output logic [NUM_PINS-1:0]   gpio_out,
   output logic [NUM_PINS-1:0]   gpio_oe
);
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         pin_code_e code;
         assign code       = pin_code_e'(out_cfg[2*i +: 2]);
         assign gpio_oe[i] = (code != PIN_OFF);

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               gpio_out[i] <= 1'b0;
            end else begin
               case (code)
                  PIN_OFF:  gpio_out[i] <= 1'b0;
                  PIN_LOW:  gpio_out[i] <= ~pulse_active;
                  PIN_HIGH: gpio_out[i] <= pulse_active;
                  default:  gpio_out[i] <= gpio_out[i];
               endcase
            end
         end

         // R11: a released pin reads low on the next cycle
         a_r11_off_low: assert property (@(posedge clk) disable iff (!rst_n)
            (code == PIN_OFF) |=> !gpio_out[i]);
      end
   endgenerate
endmodule

// File: rtl/trig_seq.sv
module trig_seq #(
   parameter int NUM_PINS    = 10,
   parameter int CNT_W       = 32,
   parameter int MIN_REP     = 256,
   parameter int SYNC_STAGES = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [NUM_PINS-1:0]   gpio_in,
   input  logic [2*NUM_PINS-1:0] cond_cfg,
   input  logic [CNT_W-1:0]      delay_cfg,
   input  logic [CNT_W-1:0]      period_cfg,
   input  logic [2*NUM_PINS-1:0] out_cfg,
   input  logic                  xmit_busy,
   output logic                  trig_strobe,
   output logic                  xmit_req,
   output logic [NUM_PINS-1:0]   gpio_out,
   output logic [NUM_PINS-1:0]   gpio_oe
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > 16) begin : g_bad_pins
         $error("trig_seq: NUM_PINS out of range");
      end
      if (CNT_W < 9) begin : g_bad_w
         $error("trig_seq: CNT_W too narrow for the repetitive period");
      end
      if (MIN_REP < 2 || MIN_REP >= (2 ** (CNT_W > 30 ? 30 : CNT_W))) begin : g_bad_rep
         $error("trig_seq: MIN_REP out of range");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("trig_seq: synchronizer needs two stages");
      end
   endgenerate

   logic [NUM_PINS-1:0] pins_s;
   logic                ext_mode;
   logic                ext_fire;
   logic                int_fire;
   logic                strobe;

   trig_sync #(.W(NUM_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (gpio_in),
      .q     (pins_s)
   );

   trig_cond_match #(.NUM_PINS(NUM_PINS)) u_match (
      .clk      (clk),
      .rst_n    (rst_n),
      .cond_cfg (cond_cfg),
      .pins     (pins_s),
      .ext_mode (ext_mode),
      .fire     (ext_fire)
   );

   trig_period_timer #(.CNT_W(CNT_W), .MIN_REP(MIN_REP)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .enable     (~ext_mode),
      .period_cfg (period_cfg),
      .fire       (int_fire)
   );

   trig_delay #(.CNT_W(CNT_W)) u_delay (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire      (ext_fire | int_fire),
      .delay_cfg (delay_cfg),
      .strobe    (strobe)
   );

   trig_out_map #(.NUM_PINS(NUM_PINS)) u_out (
      .clk          (clk),
      .rst_n        (rst_n),
      .out_cfg      (out_cfg),
      .pulse_active (xmit_busy),
      .gpio_out     (gpio_out),
      .gpio_oe      (gpio_oe)
   );

   assign trig_strobe = strobe;
   assign xmit_req    = strobe;

   // R12: the timer never fires while the pins select the trigger
   a_r12_timer_gated: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mode |-> !int_fire);
endmodule

// File: tb/tb_trig_seq.sv
module tb_trig_seq;
   localparam int N = 10;
   localparam int W = 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic [N-1:0]   gpio_in = '0;
   logic [2*N-1:0] cond_cfg = '0;
   logic [W-1:0]   delay_cfg = '0;
   logic [W-1:0]   period_cfg = '0;
   logic [2*N-1:0] out_cfg = '0;
   logic           xmit_busy = 1'b0;
   logic           trig_strobe, xmit_req;
   logic [N-1:0]   gpio_out, gpio_oe;

   trig_seq dut (
      .clk(clk), .rst_n(rst_n), .gpio_in(gpio_in), .cond_cfg(cond_cfg),
      .delay_cfg(delay_cfg), .period_cfg(period_cfg), .out_cfg(out_cfg),
      .xmit_busy(xmit_busy), .trig_strobe(trig_strobe), .xmit_req(xmit_req),
      .gpio_out(gpio_out), .gpio_oe(gpio_oe)
   );

   always #5 clk = ~clk;

   int checks = 0;
   int errors = 0;
   longint cyc = 0;
   int strobe_cnt = 0;
   longint last_strobe = 0;
   longint prev_strobe = 0;

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
      end
   endtask

   // behavioural reference model
   logic [N-1:0] m_s1, m_s2, m_out;
   bit     m_mprev, m_arm, m_busy, m_strobe, m_match, m_ext, m_int;
   longint m_per, m_pc, m_dc;

   always @(posedge clk) begin
      cyc++;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_out = '0;
         m_mprev = 0; m_arm = 0; m_busy = 0; m_strobe = 0;
         m_per = 0; m_pc = 0; m_dc = 0;
      end else begin
         m_match = 1;
         for (int i = 0; i < N; i++) begin
            if (cond_cfg[2*i +: 2] == 2'd2 && m_s2[i]) m_match = 0;
            if (cond_cfg[2*i +: 2] == 2'd3 && !m_s2[i]) m_match = 0;
         end
         m_ext = (cond_cfg != 0) && m_match && !m_mprev;
         m_int = (cond_cfg == 0) && ((m_per >= 256 && m_pc == m_per - 1) || m_arm);
         if (longint'(period_cfg) != m_per) begin
            m_pc = 0; m_arm = (period_cfg == 1); m_per = period_cfg;
         end else begin
            m_arm = 0;
            if (m_per >= 256) m_pc = (m_pc == m_per - 1) ? 0 : m_pc + 1;
         end
         m_mprev = m_match;
         m_s2 = m_s1;
         m_s1 = gpio_in;
         m_strobe = 0;
         if (m_busy) begin
            if (m_dc == 1) begin m_busy = 0; m_strobe = 1; end
            else m_dc = m_dc - 1;
         end else if (m_ext || m_int) begin
            if (delay_cfg == 0) m_strobe = 1;
            else begin m_busy = 1; m_dc = delay_cfg; end
         end
         for (int i = 0; i < N; i++) begin
            case (out_cfg[2*i +: 2])
               2'd0: m_out[i] = 1'b0;
               2'd2: m_out[i] = ~xmit_busy;
               2'd3: m_out[i] = xmit_busy;
               default: ;
            endcase
         end
      end
   end

   // per-cycle comparison against the model
   always @(negedge clk) begin
      if (trig_strobe) begin
         strobe_cnt++;
         prev_strobe = last_strobe;
         last_strobe = cyc;
      end
      if (rst_n) begin
         check(trig_strobe == m_strobe, "R5 strobe timing", trig_strobe, m_strobe);
         check(xmit_req == trig_strobe, "R10 request equals strobe", xmit_req, trig_strobe);
         check(gpio_out == m_out, "R11 output value", gpio_out, m_out);
         for (int i = 0; i < N; i++)
            check(gpio_oe[i] == (out_cfg[2*i +: 2] != 0), "R11 output enable", gpio_oe[i],
                  out_cfg[2*i +: 2] != 0);
      end
   end

   task automatic step(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
   end

   initial begin
      longint w;
      // R1 reset state
      step(3);
      check(trig_strobe == 0 && xmit_req == 0, "R1 strobe in reset", trig_strobe, 0);
      check(gpio_out == 0, "R1 outputs in reset", gpio_out, 0);
      rst_n = 1'b1;
      step(1);
      check(trig_strobe == 0 && gpio_out == 0, "R1 after release", trig_strobe, 0);

      // R2 synchronizer latency, pin 0 active high
      cond_cfg = 20'h00003;
      step(6);
      strobe_cnt = 0;
      gpio_in[0] = 1'b1;
      step(2);
      check(trig_strobe == 0, "R2 not before third edge", trig_strobe, 0);
      step(1);
      check(trig_strobe == 1, "R2 strobe after third edge", trig_strobe, 1);
      // R4 held level fires once; R3 unused pin ignored
      for (int k = 0; k < 10; k++) begin
         gpio_in[4] = ~gpio_in[4];
         step(3);
      end
      check(strobe_cnt == 1, "R4 held level fires once", strobe_cnt, 1);

      // R3 low plus high plus keep
      gpio_in = '0;
      gpio_in[3] = 1'b1;
      cond_cfg = (20'd2 << 6) | (20'd3 << 10) | (20'd1 << 14);
      step(6);
      strobe_cnt = 0;
      gpio_in[5] = 1'b1;
      step(10);
      check(strobe_cnt == 0, "R3 low pin not satisfied", strobe_cnt, 0);
      gpio_in[3] = 1'b0;
      step(10);
      check(strobe_cnt == 1, "R3 both conditions met", strobe_cnt, 1);
      for (int k = 0; k < 6; k++) begin
         gpio_in[7] = ~gpio_in[7];
         step(4);
      end
      check(strobe_cnt == 1, "R3 keep pin has no effect", strobe_cnt, 1);

      // R5 delay of 7
      gpio_in = '0;
      cond_cfg = 20'h00003;
      delay_cfg = 7;
      step(6);
      gpio_in[0] = 1'b1;
      step(9);
      check(trig_strobe == 0, "R5 not before delay", trig_strobe, 0);
      step(1);
      check(trig_strobe == 1, "R5 strobe after delay", trig_strobe, 1);
      gpio_in[0] = 1'b0;
      step(6);

      // R6 pulses spaced equal to the delay: every second one dropped
      delay_cfg = 6;
      strobe_cnt = 0;
      for (int k = 0; k < 8; k++) begin
         gpio_in[0] = 1'b1; step(3);
         gpio_in[0] = 1'b0; step(3);
      end
      step(20);
      check(strobe_cnt == 4, "R6 trigger on final countdown cycle dropped", strobe_cnt, 4);
      strobe_cnt = 0;
      for (int k = 0; k < 8; k++) begin
         gpio_in[0] = 1'b1; step(3);
         gpio_in[0] = 1'b0; step(4);
      end
      step(20);
      check(strobe_cnt == 8, "R6 trigger after countdown accepted", strobe_cnt, 8);

      // internal timer
      cond_cfg = '0;
      delay_cfg = 0;
      step(4);
      strobe_cnt = 0;
      period_cfg = 1;
      step(50);
      check(strobe_cnt == 1, "R8 single shot", strobe_cnt, 1);
      strobe_cnt = 0;
      period_cfg = 100;
      step(600);
      check(strobe_cnt == 0, "R7 period 100 stopped", strobe_cnt, 0);
      period_cfg = 0;
      step(300);
      check(strobe_cnt == 0, "R7 period 0 stopped", strobe_cnt, 0);
      strobe_cnt = 0;
      w = cyc;
      period_cfg = 300;
      step(1000);
      check(strobe_cnt >= 3, "R9 repetitive strobes", strobe_cnt, 3);
      check(last_strobe - prev_strobe == 300, "R9 spacing", last_strobe - prev_strobe, 300);
      strobe_cnt = 0;
      w = cyc;
      period_cfg = 400;
      step(450);
      check(last_strobe - w == 401, "R9 restart on write", last_strobe - w, 401);

      // R12 timer gated in pin mode
      cond_cfg = 20'h00003;
      gpio_in = '0;
      step(2);
      period_cfg = 256;
      step(4);
      strobe_cnt = 0;
      step(800);
      check(strobe_cnt == 0, "R12 timer silent in pin mode", strobe_cnt, 0);
      period_cfg = 0;

      // R11 output mapping
      out_cfg = 20'd3 | (20'd2 << 2) | (20'd1 << 4);
      xmit_busy = 1'b1;
      step(2);
      check(gpio_out[2:0] == 3'b001, "R11 high, low, keep", gpio_out[2:0], 1);
      check(gpio_oe[3:0] == 4'b0111, "R11 enables", gpio_oe[3:0], 7);
      out_cfg[5:4] = 2'd3;
      step(2);
      out_cfg[5:4] = 2'd1;
      xmit_busy = 1'b0;
      step(2);
      check(gpio_out[2:0] == 3'b110, "R11 keep holds last value", gpio_out[2:0], 6);
      for (int k = 0; k < 12; k++) begin
         xmit_busy = ~xmit_busy;
         step(k % 3 + 1);
      end
      out_cfg = '0;
      step(2);
      check(gpio_out == 0, "R11 released pins low", gpio_out, 0);

      summary();
      $finish;
   end
endmodule